// File: doc/BRIEF.md
# Radix Leaf-Entry Permission and Reference/Change Unit

This block sits beside a radix page-table walker. When the walker has fetched a leaf entry, it hands the entry to this unit together with the kind of access (load, store or instruction fetch), whether the access comes from user or supervisor state, whether the check belongs to the process-scoped or the partition-scoped stage, and a three-bit permission vector taken from the authority-mask register. One clock later the unit returns the permitted read/write/execute set, a fault flag with cause bits, and the leaf entry with its reference and change bits updated.

When the updated entry differs from the one that came in and no fault was raised, the unit asserts a write request. The caller then stores the returned entry back to the table, using the unit's output as write data. On a load or fetch, write permission is left out of the returned set. A later store to the same page therefore misses in any cache of permissions, comes back through this unit, and gets its change bit set.

Top module: `rpu_top`

## Requirements
- R1: A request accepted with `req_valid` high at a rising clock edge produces `rsp_valid` high, with all response fields, after the next rising edge. In a cycle with no request, `rsp_valid` and `wb_req` are low.
- R2: If the entry's attribute field (bits 5:4) holds 2'b10 (non-idempotent I/O) and the access is a fetch, the unit faults with the guarded/no-execute cause (bit 28). The same attribute raises no fault for loads or stores.
- R3: In a process-scoped check (`req_part`=0), a user access (`req_user`=1) to an entry with the privileged bit (bit 3) set gets an empty permission set.
- R4: In a process-scoped check, a supervisor access to an entry with bit 3 clear receives the entry's permissions ANDed with `req_amr`. In all other cases, including every partition-scoped check, the entry's permissions are used without the mask.
- R5: The entry's permissions decode as follows: bit 2 grants read, bit 1 grants read and write, bit 0 grants execute. `rsp_perm` is {exec, write, read}. `req_acc` encodes 0 = load (needs read), 1 = store (needs write), 2 = fetch (needs execute), and 3 is treated as a load.
- R6: If the required permission is missing, a fetch faults with cause bit 28 and a load or store faults with cause bit 27. On any fault `rsp_perm` is 0.
- R7: A faulting store also sets cause bit 25. No other access sets it.
- R8: Without a fault, `rsp_pte` is the entry with the reference bit (bit 8) set, and with the change bit (bit 7) also set when the access is a store. With a fault, `rsp_pte` equals the input entry.
- R9: Without a fault, a non-store access has the write bit cleared in `rsp_perm`. A store keeps it.
- R10: `wb_req` is high only when there is no fault and `rsp_pte` differs from the input entry.
- R11: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | 64 | Leaf page-table entry |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access from user state |
| req_part | input | 1 | Partition-scoped check when high |
| req_amr | input | 3 | Authority-mask permissions {exec, write, read} |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Protection fault |
| rsp_perm | output | 3 | Permitted set {exec, write, read} |
| rsp_cause | output | 32 | Fault cause bits |
| rsp_pte | output | 64 | Updated entry, also write-back data |
| wb_req | output | 1 | Write-back request |

## Verification
The bench targets the cases where the scope rules interact:
- A privileged entry under a partition-scoped check must keep its permissions. A design that applied the privilege rule in both scopes would instead fault.
- The mask must apply only to a supervisor access in the process scope. If the mask leaked into user accesses, a user store would fault; if it leaked into partition-scoped checks, supervisor reads would be denied wrongly.
- The I/O attribute must fault only on fetches. A design that faulted on loads would break device reads.
- Entries whose reference and change bits are already set must raise no write request. A design that got this wrong would write to memory on every access.
- Dropping write permission on a load shows up directly in `rsp_perm`.
- Access code 3 must behave as a load.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
    localparam int PTE_W   = 64;
    localparam int CAUSE_W = 32;

    // Leaf-entry bit positions
    localparam int B_EXEC = 0;
    localparam int B_RW   = 1;
    localparam int B_RD   = 2;
    localparam int B_PRIV = 3;
    localparam int B_ATT  = 4;   // two bits: [B_ATT+1:B_ATT]
    localparam int B_CHG  = 7;
    localparam int B_REF  = 8;

    localparam logic [1:0] ATT_NIIO = 2'b10;

    // Cause bit positions
    localparam int C_GUARD = 28;
    localparam int C_PROT  = 27;
    localparam int C_STORE = 25;

    // Permission vector positions
    localparam int P_RD = 0;
    localparam int P_WR = 1;
    localparam int P_EX = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic               vld;
        logic               fault;
        logic [2:0]         perm;
        logic [CAUSE_W-1:0] cause;
        logic [PTE_W-1:0]   pte;
        logic               wb;
    } rsp_t;
endpackage

// File: rtl/rpu_perm_sel.sv
module rpu_perm_sel
    import rpu_pkg::*;
#(
    parameter int W = PTE_W
) (
    input  logic [W-1:0] pte,
    input  logic         user,
    input  logic         part,
    input  logic [2:0]   amr,
    output logic [2:0]   perm
);
    logic [2:0] eaa;
    logic       priv;

    always_comb begin
        eaa        = '0;
        eaa[P_RD]  = pte[B_RD] | pte[B_RW];
        eaa[P_WR]  = pte[B_RW];
        eaa[P_EX]  = pte[B_EXEC];
        priv       = pte[B_PRIV];
        if (!part && priv && user) begin
            perm = 3'b000;
        end else if (!part && !priv && !user) begin
            perm = eaa & amr;
        end else begin
            perm = eaa;
        end
    end
endmodule

// File: rtl/rpu_fault_chk.sv
module rpu_fault_chk
    import rpu_pkg::*;
#(
    parameter int W  = PTE_W,
    parameter int CW = CAUSE_W
) (
    input  logic [W-1:0]  pte,
    input  logic [1:0]    acc,
    input  logic [2:0]    perm,
    output logic          fault,
    output logic [CW-1:0] cause
);
    logic       is_fetch, is_store, io_page;
    logic [2:0] need;

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        io_page  = (pte[B_ATT+1:B_ATT] == ATT_NIIO);
        need     = '0;
        if (is_fetch)      need[P_EX] = 1'b1;
        else if (is_store) need[P_WR] = 1'b1;
        else               need[P_RD] = 1'b1;

        fault = 1'b0;
        cause = '0;
        if (is_fetch && io_page) begin
            fault          = 1'b1;
            cause[C_GUARD] = 1'b1;
        end else if ((need & ~perm) != 3'b000) begin
            fault = 1'b1;
            if (is_fetch) cause[C_GUARD] = 1'b1;
            else          cause[C_PROT]  = 1'b1;
        end
        if (fault && is_store) cause[C_STORE] = 1'b1;
    end
endmodule

// File: rtl/rpu_rc_upd.sv
module rpu_rc_upd
    import rpu_pkg::*;
#(
    parameter int W = PTE_W
) (
    input  logic [W-1:0] pte,
    input  logic [1:0]   acc,
    input  logic         fault,
    input  logic [2:0]   perm_in,
    output logic [W-1:0] pte_out,
    output logic [2:0]   perm_out,
    output logic         wb
);
    logic         is_store;
    logic [W-1:0] upd;

    always_comb begin
        is_store   = (acc == ACC_STORE);
        upd        = pte;
        upd[B_REF] = 1'b1;
        if (is_store) upd[B_CHG] = 1'b1;

        if (fault) begin
            pte_out  = pte;
            perm_out = 3'b000;
            wb       = 1'b0;
        end else begin
            pte_out  = upd;
            perm_out = perm_in;
            if (!is_store) perm_out[P_WR] = 1'b0;
            wb       = (upd != pte);
        end
    end
endmodule

// File: rtl/rpu_top.sv
module rpu_top
    import rpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PTE_W-1:0]   req_pte,
    input  logic [1:0]         req_acc,
    input  logic               req_user,
    input  logic               req_part,
    input  logic [2:0]         req_amr,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [2:0]         rsp_perm,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [PTE_W-1:0]   rsp_pte,
    output logic               wb_req
);
    logic [2:0]         sel_perm;
    logic               chk_fault;
    logic [CAUSE_W-1:0] chk_cause;
    logic [PTE_W-1:0]   upd_pte;
    logic [2:0]         upd_perm;
    logic               upd_wb;
    rsp_t               rsp_d, rsp_q;

    rpu_perm_sel #(.W(PTE_W)) u_sel (
        .pte(req_pte), .user(req_user), .part(req_part),
        .amr(req_amr), .perm(sel_perm)
    );

    rpu_fault_chk #(.W(PTE_W), .CW(CAUSE_W)) u_chk (
        .pte(req_pte), .acc(req_acc), .perm(sel_perm),
        .fault(chk_fault), .cause(chk_cause)
    );

    rpu_rc_upd #(.W(PTE_W)) u_rc (
        .pte(req_pte), .acc(req_acc), .fault(chk_fault), .perm_in(sel_perm),
        .pte_out(upd_pte), .perm_out(upd_perm), .wb(upd_wb)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        rsp_d.wb  = 1'b0;
        if (req_valid) begin
            rsp_d.fault = chk_fault;
            rsp_d.perm  = upd_perm;
            rsp_d.cause = chk_cause;
            rsp_d.pte   = upd_pte;
            rsp_d.wb    = upd_wb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_fault = rsp_q.fault;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_cause = rsp_q.cause;
    assign rsp_pte   = rsp_q.pte;
    assign wb_req    = rsp_q.wb;

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    wb_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> rsp_valid);

    // R10
    no_wb_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !wb_req);

    // R6
    fault_empty_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000));

    // R8
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_pte[B_REF]);

    // R6
    cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_cause[C_GUARD] || rsp_cause[C_PROT]));

    // R9
    write_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != ACC_STORE) |=> !rsp_perm[P_WR]);

    // R7
    store_bit_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != ACC_STORE) |=> !rsp_cause[C_STORE]);
endmodule

// File: tb/rpu_top_tb.sv
module rpu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_pte = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        req_part = 1'b0;
    logic [2:0]  req_amr = '0;
    logic        rsp_valid, rsp_fault, wb_req;
    logic [2:0]  rsp_perm;
    logic [31:0] rsp_cause;
    logic [63:0] rsp_pte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] HI = 64'hA5C3_0000_1234_0000;

    // {acc[2], user, part, amr[3], pte_lo[12], exp_fault, exp_perm[3], exp_code[2]}
    // exp_code: 0 none, 1 guarded (bit 28), 2 protection (bit 27)
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 3'b111, 12'h007, 1'b0, 3'b101, 2'd0}, // R5 R9 load
        {2'd1, 1'b0, 1'b0, 3'b111, 12'h002, 1'b0, 3'b011, 2'd0}, // R8 store
        {2'd1, 1'b0, 1'b0, 3'b101, 12'h002, 1'b1, 3'b000, 2'd2}, // R4 mask denies, R7
        {2'd1, 1'b1, 1'b0, 3'b101, 12'h002, 1'b0, 3'b011, 2'd0}, // R4 user ignores mask
        {2'd0, 1'b1, 1'b0, 3'b111, 12'h00F, 1'b1, 3'b000, 2'd2}, // R3
        {2'd0, 1'b0, 1'b0, 3'b000, 12'h00C, 1'b0, 3'b001, 2'd0}, // R4 priv page, no mask
        {2'd0, 1'b1, 1'b1, 3'b000, 12'h00C, 1'b0, 3'b001, 2'd0}, // R3 partition ignores priv
        {2'd0, 1'b0, 1'b1, 3'b000, 12'h004, 1'b0, 3'b001, 2'd0}, // R4 partition no mask
        {2'd2, 1'b0, 1'b0, 3'b111, 12'h025, 1'b1, 3'b000, 2'd1}, // R2 io fetch
        {2'd2, 1'b0, 1'b0, 3'b111, 12'h035, 1'b0, 3'b101, 2'd0}, // R2 other att fetch ok
        {2'd2, 1'b0, 1'b0, 3'b111, 12'h004, 1'b1, 3'b000, 2'd1}, // R6 no exec
        {2'd0, 1'b0, 1'b0, 3'b111, 12'h104, 1'b0, 3'b001, 2'd0}, // R10 no change
        {2'd1, 1'b0, 1'b0, 3'b111, 12'h182, 1'b0, 3'b011, 2'd0}, // R10 no change store
        {2'd1, 1'b0, 1'b0, 3'b111, 12'h102, 1'b0, 3'b011, 2'd0}, // R8 change bit
        {2'd0, 1'b0, 1'b0, 3'b111, 12'h001, 1'b1, 3'b000, 2'd2}, // R6 load no read
        {2'd0, 1'b0, 1'b0, 3'b111, 12'h024, 1'b0, 3'b001, 2'd0}, // R2 io load ok
        {2'd3, 1'b0, 1'b0, 3'b111, 12'h003, 1'b0, 3'b101, 2'd0}, // R5 code 3 as load
        {2'd1, 1'b1, 1'b0, 3'b111, 12'h00A, 1'b1, 3'b000, 2'd2}  // R3 R7 user store priv
    };

    rpu_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
        .req_acc(req_acc), .req_user(req_user), .req_part(req_part),
        .req_amr(req_amr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_perm(rsp_perm), .rsp_cause(rsp_cause), .rsp_pte(rsp_pte),
        .wb_req(wb_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [24:0] v);
        req_valid = 1'b1;
        req_acc   = v[24:23];
        req_user  = v[22];
        req_part  = v[21];
        req_amr   = v[20:18];
        req_pte   = HI | {52'd0, v[17:6]};
    endtask

    task automatic expect_vec(input logic [24:0] v);
        logic [63:0] pte_in, exp_pte;
        logic [31:0] exp_cause;
        logic        f, exp_wb;
        pte_in    = HI | {52'd0, v[17:6]};
        f         = v[5];
        exp_cause = '0;
        if (v[1:0] == 2'd1) exp_cause[28] = 1'b1;
        if (v[1:0] == 2'd2) exp_cause[27] = 1'b1;
        if (f && v[24:23] == 2'd1) exp_cause[25] = 1'b1;
        exp_pte = pte_in;
        if (!f) begin
            exp_pte[8] = 1'b1;
            if (v[24:23] == 2'd1) exp_pte[7] = 1'b1;
        end
        exp_wb = !f && (exp_pte != pte_in);
        chk(rsp_valid == 1'b1, "R1 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == f, "R2/R3/R6 fault", 64'(rsp_fault), 64'(f));
        chk(rsp_cause == exp_cause, "R6/R7 cause", 64'(rsp_cause), 64'(exp_cause));
        chk(rsp_perm == v[4:2], "R4/R5/R9 perm", 64'(rsp_perm), 64'(v[4:2]));
        chk(rsp_pte == exp_pte, "R8 pte", rsp_pte, exp_pte);
        chk(wb_req == exp_wb, "R10 wb_req", 64'(wb_req), 64'(exp_wb));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        // R11 reset state, with a request pending during reset
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0 && wb_req == 0 && rsp_fault == 0, "R11 reset ctrl",
            {61'd0, rsp_valid, wb_req, rsp_fault}, 64'd0);
        chk(rsp_pte == '0 && rsp_perm == '0 && rsp_cause == '0, "R11 reset data",
            rsp_pte, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);

        // table, back-to-back requests
        drive(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            expect_vec(VEC[i]);
            if (i + 1 < NV) drive(VEC[i + 1]);
            else            req_valid = 1'b0;
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && wb_req == 1'b0, "R1 idle no rsp/wb",
            {62'd0, rsp_valid, wb_req}, 64'd0);

        // gap then single request: changing store
        drive(VEC[13]);
        @(negedge clk);
        req_valid = 1'b0;
        expect_vec(VEC[13]);
        @(negedge clk);
        chk(wb_req == 1'b0, "R10 wb single pulse", 64'(wb_req), 64'd0);

        // R11 reset mid-stream clears outputs
        drive(VEC[1]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 0 && wb_req == 0 && rsp_pte == '0, "R11 reset again",
            rsp_pte, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule